// File: doc/BRIEF.md
# Multi-Output Ratio Clock Divider

This block takes one fast oscillator clock and derives five slower clocks from it: a processor clock, a memory clock, a hub clock, a bus clock at half the hub rate and an interrupt-controller clock at half the bus rate. A 4-bit selection code picks the processor, memory and hub ratios together. Odd ratios of 3 are included, and every output keeps an exact 50% duty cycle. The design runs at half-cycle resolution: each source cycle produces a pair of half-cycle values, and a final multiplexer on the source clock level drives the outputs.

All five counters start together. A full interrupt-controller period, which is 4x the hub ratio, is a multiple of every other ratio, so the end of that period is a point where all counters wrap at once. This point is the frame boundary. The configuration FSM has two states. In CFG_STEADY the applied settings match the inputs. It moves to CFG_PENDING when they differ at any cycle other than a frame boundary. From CFG_PENDING it returns to CFG_STEADY at the next frame boundary, and the new settings are loaded there. A difference seen right at a boundary is loaded at once, and the FSM stays in CFG_STEADY.

Each output has a gate FSM with two states, GATE_ON and GATE_OFF. It moves between them only at the end of that output's own period, so a stop finishes the current pulse and a restart begins a full pulse. The memory output has a 3-bit skew code, and the hub, bus and interrupt outputs share a second one. Each skew code shifts its outputs by (code - 4) half source cycles relative to the processor clock.

Top module: `multi_clk_divider`

## Requirements
- R1: With div_sel[3]=0, div_sel[2:0] values 0 through 7 give processor ratios 4,3,2,2,6,3,6,4 and memory ratios 4,3,3,2,4,4,3,3 (in source cycles), and the hub ratio is 6.
- R2: With div_sel[3]=1, div_sel[2]=0 gives processor 2, memory 2, hub 4. div_sel[2]=1 gives processor 2, memory 4, hub 6. div_sel[1:0] has no effect in either case.
- R3: The bus clock period is 2x and the interrupt clock period 4x the hub period, and both rise in the same half-cycle as the hub clock at a frame boundary.
- R4: Every output with ratio N is high for exactly N half source cycles out of 2N, odd N included.
- R5: At a frame boundary the memory clock rises (mem_skew - 4) half source cycles after the processor clock, and the hub clock rises (hub_skew - 4) half source cycles after it.
- R6: Changes on div_sel, mem_skew and hub_skew are applied only at a frame boundary, so every high or low pulse of an output has the length of either the old or the new ratio.
- R7: When out_en is cleared, an output completes its current period and then stays low. When out_en is set again, it resumes with a full pulse at the start of its own period.
- R8: While rst is high all outputs are low. After reset, settings of div_sel=0000 and both skews 100 apply until the first frame boundary.
- R9: out_en bit 0 gates the processor clock, bit 1 the memory clock, bit 2 the hub clock, bit 3 the bus clock and bit 4 the interrupt clock. Each bit affects only its own output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_vco | input | 1 | Fast source clock |
| rst | input | 1 | Synchronous reset, active high |
| div_sel | input | 4 | Joint ratio selection code |
| mem_skew | input | 3 | Memory clock offset code |
| hub_skew | input | 3 | Hub, bus and interrupt clock offset code |
| out_en | input | 5 | Per-output run enables |
| cpu_clk | output | 1 | Processor clock |
| mem_clk | output | 1 | Memory clock |
| hub_clk | output | 1 | Hub clock |
| pci_clk | output | 1 | Bus clock, half the hub rate |
| apic_clk | output | 1 | Interrupt clock, half the bus rate |

## Verification
The bench covers odd ratios of 3, where an error in half-cycle handling shows up as a high time of 1 or 2 half-cycles instead of 3. It changes the selection code in the middle of a frame, where a design that loads the code at once would leave a cut or stretched pulse between the two ratios. It clears and then sets an enable mid-period, where a gate that is not tied to the period boundary would produce a runt pulse or restart out of phase. It also uses the extreme skew codes 0 and 7 and selection codes that differ only in the ignored bits. A wrong delay index would move a rising edge away from its expected offset relative to the processor clock, and decoding the ignored bits would change a ratio.

// File: rtl/mcd_pkg.sv
package mcd_pkg;
    localparam int NUM_OUT = 5;
    localparam int SEL_W   = 4;
    localparam int RW      = 5;
    localparam int DLY_W   = 3;
    localparam int HIST_W  = (1 << DLY_W) + 1;
    localparam int IDX_W   = $clog2(HIST_W);
    localparam int CPU_DLY = 4;

    localparam int OUT_CPU  = 0;
    localparam int OUT_MEM  = 1;
    localparam int OUT_HUB  = 2;
    localparam int OUT_PCI  = 3;
    localparam int OUT_APIC = 4;

    typedef logic [RW-1:0] ratio_t;

    typedef enum logic {CFG_STEADY, CFG_PENDING} cfg_state_t;
    typedef enum logic {GATE_ON, GATE_OFF} gate_state_t;
endpackage

// File: rtl/mcd_ratio_decode.sv
module mcd_ratio_decode
    import mcd_pkg::*;
(
    input  logic [SEL_W-1:0]              sel,
    output logic [NUM_OUT-1:0][RW-1:0]    ratios
);
    ratio_t cpu_r, mem_r, hub_r;

    always_comb begin
        if (sel[3]) begin
            cpu_r = RW'(2);
            mem_r = sel[2] ? RW'(4) : RW'(2);
            hub_r = sel[2] ? RW'(6) : RW'(4);
        end else begin
            hub_r = RW'(6);
            unique case (sel[2:0])
                3'd0: begin cpu_r = RW'(4); mem_r = RW'(4); end
                3'd1: begin cpu_r = RW'(3); mem_r = RW'(3); end
                3'd2: begin cpu_r = RW'(2); mem_r = RW'(3); end
                3'd3: begin cpu_r = RW'(2); mem_r = RW'(2); end
                3'd4: begin cpu_r = RW'(6); mem_r = RW'(4); end
                3'd5: begin cpu_r = RW'(3); mem_r = RW'(4); end
                3'd6: begin cpu_r = RW'(6); mem_r = RW'(3); end
                default: begin cpu_r = RW'(4); mem_r = RW'(3); end
            endcase
        end
    end

    always_comb begin
        ratios[OUT_CPU]  = cpu_r;
        ratios[OUT_MEM]  = mem_r;
        ratios[OUT_HUB]  = hub_r;
        ratios[OUT_PCI]  = hub_r << 1;
        ratios[OUT_APIC] = hub_r << 2;
    end

    // R1
    always_comb begin
        ratio_legal_chk: assert (cpu_r inside {RW'(2), RW'(3), RW'(4), RW'(6)});
    end
endmodule

// File: rtl/mcd_wave_gen.sv
module mcd_wave_gen
    import mcd_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  ratio_t        ratio,
    input  logic          en,
    output ratio_t        cnt_o,
    output logic [1:0]    pair_o
);
    ratio_t      cnt_q;
    gate_state_t gate_q, gate_d;
    logic        period_end;
    logic        gate_on;

    assign period_end = (cnt_q >= ratio - RW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= period_end ? '0 : cnt_q + RW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_q <= GATE_ON;
        end else begin
            gate_q <= gate_d;
        end
    end

    always_comb begin
        gate_d = gate_q;
        unique case (gate_q)
            GATE_ON:  if (period_end && !en) gate_d = GATE_OFF;
            GATE_OFF: if (period_end && en)  gate_d = GATE_ON;
            default:  gate_d = GATE_ON;
        endcase
    end

    always_comb begin
        gate_on   = (gate_q == GATE_ON);
        pair_o[1] = gate_on && ({cnt_q, 1'b0} < {1'b0, ratio});
        pair_o[0] = gate_on && ({cnt_q, 1'b1} < {1'b0, ratio});
        cnt_o     = cnt_q;
    end

    // R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q < ratio);

    // R7
    gate_move_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(gate_q) |-> (cnt_q == '0));
endmodule

// File: rtl/mcd_skew_line.sv
module mcd_skew_line
    import mcd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       pair_i,
    input  logic [DLY_W-1:0] dly,
    output logic             wave_o
);
    logic [HIST_W-1:0] hist_q;
    logic [IDX_W-1:0]  lo_idx, hi_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '0;
        end else begin
            hist_q <= {hist_q[HIST_W-3:0], pair_i};
        end
    end

    assign lo_idx = IDX_W'(dly);
    assign hi_idx = IDX_W'(dly) + IDX_W'(1);
    assign wave_o = clk ? hist_q[hi_idx] : hist_q[lo_idx];
endmodule

// File: rtl/multi_clk_divider.sv
module multi_clk_divider
    import mcd_pkg::*;
(
    input  logic             clk_vco,
    input  logic             rst,
    input  logic [3:0]       div_sel,
    input  logic [2:0]       mem_skew,
    input  logic [2:0]       hub_skew,
    input  logic [4:0]       out_en,
    output logic             cpu_clk,
    output logic             mem_clk,
    output logic             hub_clk,
    output logic             pci_clk,
    output logic             apic_clk
);
    cfg_state_t              cfg_state_q, cfg_state_d;
    logic [SEL_W-1:0]        code_q;
    logic [DLY_W-1:0]        mskew_q, hskew_q;
    logic [NUM_OUT-1:0][RW-1:0] ratios;
    ratio_t                  cnt_w [NUM_OUT];
    logic [NUM_OUT-1:0]      wave_w;
    logic                    frame_wrap;
    logic                    differ;
    logic                    load_cfg;

    mcd_ratio_decode u_decode (
        .sel    (code_q),
        .ratios (ratios)
    );

    assign frame_wrap = (cnt_w[OUT_APIC] == ratios[OUT_APIC] - RW'(1));
    assign differ     = (div_sel != code_q) || (mem_skew != mskew_q) ||
                        (hub_skew != hskew_q);

    always_ff @(posedge clk_vco) begin
        if (rst) begin
            cfg_state_q <= CFG_STEADY;
        end else begin
            cfg_state_q <= cfg_state_d;
        end
    end

    always_comb begin
        cfg_state_d = cfg_state_q;
        unique case (cfg_state_q)
            CFG_STEADY:  if (differ && !frame_wrap) cfg_state_d = CFG_PENDING;
            CFG_PENDING: if (frame_wrap)            cfg_state_d = CFG_STEADY;
            default:     cfg_state_d = CFG_STEADY;
        endcase
    end

    always_comb begin
        unique case (cfg_state_q)
            CFG_STEADY:  load_cfg = frame_wrap && differ;
            CFG_PENDING: load_cfg = frame_wrap;
            default:     load_cfg = 1'b0;
        endcase
    end

    always_ff @(posedge clk_vco) begin
        if (rst) begin
            code_q  <= '0;
            mskew_q <= DLY_W'(CPU_DLY);
            hskew_q <= DLY_W'(CPU_DLY);
        end else if (load_cfg) begin
            code_q  <= div_sel;
            mskew_q <= mem_skew;
            hskew_q <= hub_skew;
        end
    end

    for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
        logic [1:0]       pair;
        logic [DLY_W-1:0] dly;

        if (k == OUT_CPU) begin : g_cpu
            assign dly = DLY_W'(CPU_DLY);
        end else if (k == OUT_MEM) begin : g_mem
            assign dly = mskew_q;
        end else begin : g_hub
            assign dly = hskew_q;
        end

        mcd_wave_gen u_wave (
            .clk    (clk_vco),
            .rst    (rst),
            .ratio  (ratios[k]),
            .en     (out_en[k]),
            .cnt_o  (cnt_w[k]),
            .pair_o (pair)
        );

        mcd_skew_line u_skew (
            .clk    (clk_vco),
            .rst    (rst),
            .pair_i (pair),
            .dly    (dly),
            .wave_o (wave_w[k])
        );
    end

    assign cpu_clk  = wave_w[OUT_CPU];
    assign mem_clk  = wave_w[OUT_MEM];
    assign hub_clk  = wave_w[OUT_HUB];
    assign pci_clk  = wave_w[OUT_PCI];
    assign apic_clk = wave_w[OUT_APIC];

    // R6
    frame_align_chk: assert property (@(posedge clk_vco) disable iff (rst)
        frame_wrap |=> (cnt_w[OUT_CPU] == '0 && cnt_w[OUT_MEM] == '0 &&
                        cnt_w[OUT_HUB] == '0 && cnt_w[OUT_PCI] == '0));

    // R6
    cfg_hold_chk: assert property (@(posedge clk_vco) disable iff (rst)
        (cfg_state_q == CFG_PENDING && !frame_wrap) |=>
            ($stable(code_q) && $stable(mskew_q) && $stable(hskew_q)));
endmodule

// File: tb/multi_clk_divider_bench.sv
module multi_clk_divider_bench;
    localparam int NS = 200;
    localparam int NV = 12;
    // {sel[3:0], mem_skew[2:0], hub_skew[2:0], cpu[4:0], mem[4:0], hub[4:0]}
    localparam logic [24:0] VEC [NV] = '{
        {4'b0000, 3'd4, 3'd4, 5'd4, 5'd4, 5'd6},
        {4'b0001, 3'd0, 3'd7, 5'd3, 5'd3, 5'd6},
        {4'b0010, 3'd7, 3'd0, 5'd2, 5'd3, 5'd6},
        {4'b0011, 3'd2, 3'd5, 5'd2, 5'd2, 5'd6},
        {4'b0100, 3'd5, 3'd3, 5'd6, 5'd4, 5'd6},
        {4'b0101, 3'd1, 3'd6, 5'd3, 5'd4, 5'd6},
        {4'b0110, 3'd6, 3'd1, 5'd6, 5'd3, 5'd6},
        {4'b0111, 3'd3, 3'd2, 5'd4, 5'd3, 5'd6},
        {4'b1000, 3'd4, 3'd4, 5'd2, 5'd2, 5'd4},
        {4'b1011, 3'd0, 3'd7, 5'd2, 5'd2, 5'd4},
        {4'b1100, 3'd7, 3'd3, 5'd2, 5'd4, 5'd6},
        {4'b1110, 3'd4, 3'd4, 5'd2, 5'd4, 5'd6}
    };

    logic       clk_vco = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] div_sel = 4'b0000;
    logic [2:0] mem_skew = 3'd4;
    logic [2:0] hub_skew = 3'd4;
    logic [4:0] out_en = 5'b11111;
    logic       cpu_clk, mem_clk, hub_clk, pci_clk, apic_clk;
    logic [4:0] ov;
    logic       smp [5][NS];
    int         n_chk = 0;
    int         n_err = 0;
    bit         done = 1'b0;

    assign ov = {apic_clk, pci_clk, hub_clk, mem_clk, cpu_clk};

    always #2 clk_vco = ~clk_vco;

    multi_clk_divider u_multi_clk_divider (
        .clk_vco  (clk_vco),
        .rst      (rst),
        .div_sel  (div_sel),
        .mem_skew (mem_skew),
        .hub_skew (hub_skew),
        .out_en   (out_en),
        .cpu_clk  (cpu_clk),
        .mem_clk  (mem_clk),
        .hub_clk  (hub_clk),
        .pci_clk  (pci_clk),
        .apic_clk (apic_clk)
    );

    task automatic chk(input bit ok, input string rq, input int act,
                       input int exp, input string what);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(posedge clk_vco);
        #1;
    endtask

    task automatic capture(input int tog, input logic [4:0] en_v,
                           input logic [3:0] sel_v);
        for (int c = 0; c < NS / 2; c++) begin
            @(posedge clk_vco); #1;
            for (int k = 0; k < 5; k++) smp[k][2*c] = ov[k];
            if (c == tog) begin
                out_en  = en_v;
                div_sel = sel_v;
            end
            @(negedge clk_vco); #1;
            for (int k = 0; k < 5; k++) smp[k][2*c+1] = ov[k];
        end
    endtask

    function automatic bit rise(input int k, input int i);
        return smp[k][i] && !smp[k][i-1];
    endfunction

    task automatic analyze(input int ms, input int hs, input int n [5],
                           input string rr);
        int f = -1;
        for (int i = 9; i < NS; i++) if (f < 0 && rise(4, i)) f = i - hs;
        chk(f >= 0, "R3", f, 0, "interrupt clock rising edge found");
        if (f < 0) return;
        for (int k = 0; k < 5; k++) begin
            int d = (k == 0) ? 4 : (k == 1) ? ms : hs;
            int r = f + d;
            int hi = 0;
            chk(rise(k, r), (k >= 3) ? "R3" : "R5", smp[k][r], 1,
                $sformatf("out%0d aligned rise", k));
            for (int i = r; i < r + 2*n[k]; i++) hi += smp[k][i];
            chk(hi == n[k], "R4", hi, n[k], $sformatf("out%0d high halves", k));
            chk(rise(k, r + 2*n[k]), (k < 3) ? rr : "R3", smp[k][r+2*n[k]], 1,
                $sformatf("out%0d period %0d", k, 2*n[k]));
        end
    endtask

    task automatic check_runs(input int k, input int na, input int nb,
                              input bit lows, input string rq);
        int st = 0;
        for (int i = 1; i < NS; i++) begin
            if (smp[k][i] != smp[k][i-1]) begin
                if (st > 0 && (smp[k][i-1] || lows))
                    chk((i - st) == na || (i - st) == nb, rq, i - st, na,
                        $sformatf("out%0d pulse length", k));
                st = i;
            end
        end
    endtask

    initial begin
        int n [5];
        int cnt;
        int r0, r1;
        // R8: outputs low during reset
        wait_cycles(4);
        @(negedge clk_vco); #1;
        chk(ov == 5'b0, "R8", ov, 0, "outputs low in reset (second half)");
        @(posedge clk_vco); #1;
        chk(ov == 5'b0, "R8", ov, 0, "outputs low in reset (first half)");
        // R8: defaults apply before first frame boundary
        div_sel = 4'b0010; mem_skew = 3'd0; hub_skew = 3'd7;
        rst = 1'b0;
        capture(-1, 5'b11111, 4'b0010);
        r0 = -1; r1 = -1;
        for (int i = 1; i < NS; i++) if (r0 < 0 && rise(0, i)) r0 = i;
        for (int i = 1; i < NS; i++) if (r1 < 0 && rise(1, i)) r1 = i;
        cnt = 0;
        if (r0 > 0) for (int i = r0; i < NS && smp[0][i]; i++) cnt++;
        chk(cnt == 4, "R8", cnt, 4, "first processor pulse uses default ratio");
        chk(r1 == r0, "R8", r1, r0, "first memory rise uses default skew");

        // R1 R2 R3 R4 R5: vector table
        for (int v = 0; v < NV; v++) begin
            logic [24:0] e = VEC[v];
            div_sel = e[24:21]; mem_skew = e[20:18]; hub_skew = e[17:15];
            n[0] = int'(e[14:10]); n[1] = int'(e[9:5]); n[2] = int'(e[4:0]);
            n[3] = 2 * n[2]; n[4] = 4 * n[2];
            wait_cycles(60);
            capture(-1, 5'b11111, div_sel);
            analyze(int'(e[20:18]), int'(e[17:15]), n, e[24] ? "R2" : "R1");
        end

        // R7 R9: stop the processor clock mid-window
        div_sel = 4'b0001; mem_skew = 3'd4; hub_skew = 3'd4;
        wait_cycles(60);
        capture(30, 5'b11110, 4'b0001);
        check_runs(0, 3, 3, 1'b0, "R7");
        cnt = 0;
        for (int i = 120; i < NS; i++) cnt += smp[0][i];
        chk(cnt == 0, "R7", cnt, 0, "stopped processor clock held low");
        cnt = 0;
        for (int i = 120; i < NS; i++) cnt += smp[1][i];
        chk(cnt > 0, "R9", cnt, 1, "memory clock keeps running");
        // R7: restart
        capture(30, 5'b11111, 4'b0001);
        check_runs(0, 3, 3, 1'b0, "R7");
        capture(-1, 5'b11111, 4'b0001);
        n[0] = 3; n[1] = 3; n[2] = 6; n[3] = 12; n[4] = 24;
        analyze(4, 4, n, "R7");

        // R9: interrupt clock bit only
        out_en = 5'b01111;
        wait_cycles(60);
        capture(-1, 5'b01111, 4'b0001);
        cnt = 0;
        for (int i = 0; i < NS; i++) cnt += smp[4][i];
        chk(cnt == 0, "R9", cnt, 0, "interrupt clock stopped by bit 4");
        cnt = 0;
        for (int i = 0; i < NS; i++) cnt += smp[0][i];
        chk(cnt > 0, "R9", cnt, 1, "processor clock unaffected by bit 4");
        out_en = 5'b11111;
        wait_cycles(60);

        // R6: code changes mid-frame
        capture(30, 5'b11111, 4'b0000);
        check_runs(0, 3, 4, 1'b1, "R6");
        check_runs(1, 3, 4, 1'b1, "R6");
        div_sel = 4'b0100;
        wait_cycles(60);
        capture(20, 5'b11111, 4'b1000);
        check_runs(0, 6, 2, 1'b1, "R6");
        check_runs(2, 6, 4, 1'b1, "R6");
        check_runs(4, 24, 16, 1'b1, "R6");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual 0 expected 1 completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule